// File: doc/BRIEF.md
# Dual-Codec TDM Slot Interleaver

This block lets one host serial port carry sixteen 16-bit channels that come from two codecs. Each codec produces 32-bit slots, but only the upper half-word of each slot carries useful audio. The two codecs share the host bit clock. The second codec gets its own frame sync, placed half a slot (16 bit clocks) after the host's sync. Its upper half-word therefore lands in the bit times where the first codec is sending its discarded lower half. A select signal switches a 2:1 data path every half slot, so the host sees one packed frame.

The host launches its frame sync on the falling bit-clock edge, and every receiver samples on the rising edge. The block follows the same rule. It tracks the frame position on rising edges and launches the delayed sync and the select on falling edges. Each control is then stable for half a bit period on both sides of the rising edge that samples it.

The merged serial data is a plain combinational multiplexer, so it adds no latency. A framing monitor flags a sync that arrives at the wrong position, or that fails to arrive when the frame ends. After a missing sync, the block re-aligns on the next sync it sees.

Top module: `tdm_pair_merger`

## Requirements
- R1: Bit position 0 is the rising edge at which `fs_host` is sampled high. Positions then count up to FRAME_BITS-1 (default 256) and wrap to 0. While syncs keep arriving exactly at position 0, `frame_err` stays low.
- R2: While locked, `fs_b_out` goes high on the falling edge just before the rising edge of position HALF_BITS (default 16). It stays high for exactly one bit clock, once per frame.
- R3: While locked, `sel_out` is 0 (first codec) for positions 0 to HALF_BITS-1 of every 2*HALF_BITS slot and 1 (second codec) for the other half. It changes only on the falling edge that precedes the position.
- R4: `sd_out` equals `sd_a` when `sel_out` is 0 and equals `sd_b` when `sel_out` is 1, combinationally in the same bit time.
- R5: From reset until the first sampled `fs_host`, `sel_out` and `fs_b_out` stay 0.
- R6: If `fs_host` is sampled high while locked at a position other than 0, `frame_err` is high for the one bit clock after that rising edge. That edge becomes position 0.
- R7: If position 0 is reached while locked and `fs_host` is low, `frame_err` pulses for one bit clock. The block then unlocks, with `sel_out` and `fs_b_out` at 0, until the next sampled `fs_host`.
- R8: `rst_n` low drives all outputs except `sd_out` to 0 at once, without a clock. Release takes effect through a two-stage synchronizer on the rising bit-clock edge.
- FRAME_BITS and HALF_BITS must be powers of two, with 2*HALF_BITS no larger than FRAME_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Shared bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_host | input | 1 | Host frame sync, one bit clock wide, launched on the falling edge |
| sd_a | input | 1 | Serial data from the first codec |
| sd_b | input | 1 | Serial data from the second codec |
| fs_b_out | output | 1 | Frame sync for the second codec, delayed by HALF_BITS |
| sel_out | output | 1 | Data source select: 0 first codec, 1 second codec |
| sd_out | output | 1 | Merged serial data to the host |
| frame_err | output | 1 | One-bit-clock pulse on an early or missing frame sync |

## Verification
The bench builds the block with FRAME_BITS=64 and HALF_BITS=8. Each frame then holds four slots, and a wrap of the position counter comes every 64 bit clocks. Within the cycle budget this allows dozens of complete frames, each with its own randomly chosen pattern of early syncs, dropped syncs and re-locks. The select and delayed-sync timing are still checked on every slot boundary and every frame boundary.

// File: rtl/tdm_merge_pkg.sv
`timescale 1ns/1ps
package tdm_merge_pkg;
  localparam int DEF_FRAME_BITS = 256;
  localparam int DEF_HALF_BITS  = 16;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;
endpackage

// File: rtl/tdm_rst_sync.sv
`timescale 1ns/1ps
module tdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/tdm_frame_tracker.sv
`timescale 1ns/1ps
module tdm_frame_tracker #(
  parameter int FRAME_BITS = tdm_merge_pkg::DEF_FRAME_BITS,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_in,
  output logic [CW-1:0] next_pos_q,
  output logic          locked_q,
  output logic          err_q
);
  logic [CW-1:0] next_pos_d;
  logic          locked_d;
  logic          err_d;
  logic          at_start;

  assign at_start = (next_pos_q == '0);

  always_comb begin
    next_pos_d = (next_pos_q == CW'(FRAME_BITS - 1)) ? '0 : next_pos_q + CW'(1);
    locked_d   = locked_q;
    err_d      = 1'b0;
    if (fs_in) begin
      next_pos_d = CW'(1);
      locked_d   = 1'b1;
      err_d      = locked_q && !at_start;
    end else if (locked_q && at_start) begin
      locked_d   = 1'b0;
      err_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pos_q <= '0;
      locked_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      next_pos_q <= next_pos_d;
      locked_q   <= locked_d;
      err_q      <= err_d;
    end
  end
endmodule

// File: rtl/tdm_edge_launch.sv
`timescale 1ns/1ps
module tdm_edge_launch #(
  parameter int FRAME_BITS = tdm_merge_pkg::DEF_FRAME_BITS,
  parameter int HALF_BITS  = tdm_merge_pkg::DEF_HALF_BITS,
  localparam int CW   = $clog2(FRAME_BITS),
  localparam int HB_W = $clog2(HALF_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       next_pos,
  input  logic                locked,
  output tdm_merge_pkg::src_e sel_q,
  output logic                fsb_q
);
  import tdm_merge_pkg::*;

  src_e sel_d;
  logic fsb_d;

  always_comb begin
    sel_d = (locked && next_pos[HB_W]) ? SRC_B : SRC_A;
    fsb_d = locked && (next_pos == CW'(HALF_BITS));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_A;
      fsb_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      fsb_q <= fsb_d;
    end
  end
endmodule

// File: rtl/tdm_pair_merger.sv
`timescale 1ns/1ps
module tdm_pair_merger #(
  parameter int FRAME_BITS = tdm_merge_pkg::DEF_FRAME_BITS,
  parameter int HALF_BITS  = tdm_merge_pkg::DEF_HALF_BITS
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic fs_host,
  input  logic sd_a,
  input  logic sd_b,
  output logic fs_b_out,
  output logic sel_out,
  output logic sd_out,
  output logic frame_err
);
  import tdm_merge_pkg::*;
  localparam int CW = $clog2(FRAME_BITS);

  logic          srst_n;
  logic [CW-1:0] next_pos;
  logic          locked;
  src_e          sel_src;

  tdm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (bclk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  tdm_frame_tracker #(.FRAME_BITS(FRAME_BITS)) u_track (
    .clk        (bclk),
    .rst_n      (srst_n),
    .fs_in      (fs_host),
    .next_pos_q (next_pos),
    .locked_q   (locked),
    .err_q      (frame_err)
  );

  tdm_edge_launch #(.FRAME_BITS(FRAME_BITS), .HALF_BITS(HALF_BITS)) u_launch (
    .clk      (bclk),
    .rst_n    (srst_n),
    .next_pos (next_pos),
    .locked   (locked),
    .sel_q    (sel_src),
    .fsb_q    (fs_b_out)
  );

  assign sel_out = (sel_src == SRC_B);
  assign sd_out  = (sel_src == SRC_B) ? sd_b : sd_a;
endmodule

// File: rtl/tdm_pair_merger_chk.sv
`timescale 1ns/1ps
module tdm_pair_merger_chk #(
  parameter int HALF_BITS = tdm_merge_pkg::DEF_HALF_BITS,
  localparam int RW = $clog2(HALF_BITS + 1) + 1
) (
  input logic bclk,
  input logic rst_n,
  input logic fs_host,
  input logic fs_b_out,
  input logic sel_out,
  input logic frame_err
);
  logic [RW-1:0] run_q;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (sel_out) run_q <= run_q + RW'(1);
    else              run_q <= '0;
  end

  AST_FSB_ONE_WIDE: assert property (@(negedge bclk) disable iff (!rst_n)
    fs_b_out |=> !fs_b_out); // R2

  AST_FSB_AT_HALF_SWITCH: assert property (@(negedge bclk) disable iff (!rst_n)
    fs_b_out |-> (sel_out && !$past(sel_out))); // R3

  AST_SEL_RUN_BOUND: assert property (@(posedge bclk) disable iff (!rst_n)
    run_q <= RW'(HALF_BITS)); // R3

  AST_EARLY_SYNC_FLAG: assert property (@(posedge bclk) disable iff (!rst_n)
    (fs_host && sel_out) |=> frame_err); // R6
endmodule

bind tdm_pair_merger tdm_pair_merger_chk #(.HALF_BITS(HALF_BITS)) u_chk (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .fs_host   (fs_host),
  .fs_b_out  (fs_b_out),
  .sel_out   (sel_out),
  .frame_err (frame_err)
);

// File: tb/tdm_pair_merger_tb_top.sv
`timescale 1ns/1ps
module tdm_pair_merger_tb_top;
  localparam int FB = 64;
  localparam int HB = 8;

  logic clk = 1'b0;
  logic rst_n, fs_host, sd_a, sd_b;
  logic fs_b_out, sel_out, sd_out, frame_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit    m_locked = 0;
  int    m_next   = 0;
  bit    m_err    = 0;
  string m_err_tag = "R1";

  always #2.5 clk = ~clk;

  tdm_pair_merger #(.FRAME_BITS(FB), .HALF_BITS(HB)) dut_i (
    .bclk(clk), .rst_n(rst_n), .fs_host(fs_host), .sd_a(sd_a), .sd_b(sd_b),
    .fs_b_out(fs_b_out), .sel_out(sel_out), .sd_out(sd_out), .frame_err(frame_err)
  );

  function automatic bit exp_sel_f(bit lk, int nx);
    return lk && ((nx % (2 * HB)) >= HB);
  endfunction

  function automatic bit exp_fsb_f(bit lk, int nx);
    return lk && (nx == HB);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one bit time: check launched controls, drive host/codec bits, then update model at rising edge
  task automatic step(bit fs_v);
    bit es, ef, a, b;
    @(negedge clk); #1;
    es = exp_sel_f(m_locked, m_next);
    ef = exp_fsb_f(m_locked, m_next);
    chk(sel_out === es, m_locked ? "R3 select phase" : "R5 select idle", sel_out, es);
    chk(fs_b_out === ef, m_locked ? "R2 delayed sync" : "R5 delayed sync idle", fs_b_out, ef);
    chk(frame_err === m_err, m_err_tag, frame_err, m_err);
    a = 1'($urandom); b = 1'($urandom);
    fs_host = fs_v; sd_a = a; sd_b = b;
    #1;
    chk(sd_out === (es ? b : a), "R4 merged data", sd_out, es ? b : a);
    @(posedge clk);
    if (!rst_n) begin
      m_locked = 0; m_next = 0; m_err = 0; m_err_tag = "R8 reset err";
    end else if (fs_v) begin
      m_err = m_locked && (m_next != 0);
      m_err_tag = m_err ? "R6 early sync" : "R1 aligned sync";
      m_locked = 1; m_next = 1;
    end else if (m_locked && m_next == 0) begin
      m_err = 1; m_err_tag = "R7 missing sync"; m_locked = 0;
    end else begin
      m_err = 0; m_err_tag = "R1 no error";
      m_next = (m_next + 1) % FB;
    end
  endtask

  task automatic frame_n(int len);
    for (int i = 0; i < len; i++) step(i == 0);
  endtask

  task automatic idle_n(int len);
    for (int i = 0; i < len; i++) step(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; fs_host = 1'b0; sd_a = 1'b0; sd_b = 1'b0;
    #1;
    chk(sel_out === 1'b0 && fs_b_out === 1'b0 && frame_err === 1'b0, "R8 reset outputs", {sel_out, fs_b_out, frame_err}, 0);
    repeat (3) step(1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle_n(20);                         // R5: no sync yet
    for (int f = 0; f < 6; f++) frame_n(FB);   // R1 R2 R3 regular frames
    frame_n(13); frame_n(FB); frame_n(FB);     // R6 early sync at position 13
    frame_n(FB); idle_n(FB); idle_n(30);       // R7 missing sync, unlock
    frame_n(FB); frame_n(FB);                  // relock
    // R8: asynchronous reset while select is on the second codec
    frame_n(HB + 2);
    @(negedge clk); #1;
    chk(sel_out === 1'b1, "R3 pre-reset select", sel_out, 1);
    rst_n = 1'b0; #1;
    chk(sel_out === 1'b0 && fs_b_out === 1'b0, "R8 async clear", {sel_out, fs_b_out}, 0);
    m_locked = 0; m_next = 0; m_err = 0;
    repeat (3) step(1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle_n(6);
    // constrained random frames
    for (int f = 0; f < 40; f++) begin
      int r;
      r = $urandom_range(7);
      if (r == 0)      frame_n($urandom_range(FB - 1, 1));
      else if (r == 1) idle_n(FB);
      else if (r == 2) begin idle_n($urandom_range(5)); frame_n(FB); end
      else             frame_n(FB);
    end
    frame_n(FB);
    summary();
  end
endmodule